// File: doc/BRIEF.md
# End-of-Write Status Poller

After a host has issued a program or erase command to a byte-wide flash device, this controller decides when that write has finished. It reads one target address again and again through a simple read request/response interface. Each returned byte is judged by one of three completion tests, picked by an input when polling starts. The first test compares the top data bit against the true value of the byte that was written, because the device inverts that bit while it is busy. The second test watches bit 6, which the device flips on every read while it is busy. The third test waits for two back-to-back reads that return the same byte.

A read can land at the very moment the internal write finishes. It may then look complete while carrying data that is still settling. To guard against this, a completion whose byte differs from the expected value is never reported as failed at once. The poller reads the location twice more, passes only if both rereads return the expected byte, and otherwise confirms the failure. A watchdog in clock cycles bounds each poll. One parameter covers byte program and sector erase, and a longer one covers whole-chip erase. If the limit runs out before completion is seen, the poller ends with a timeout.

Top module: `eow_poller`

## Requirements
- R1: After reset, busy, done, pass, timeout and rd_req are all 0.
- R2: The method code, expected byte, address and limit choice are captured on the cycle a start is accepted in idle. Every read of that poll uses the captured address. Changes on those inputs, and further start pulses, have no effect until done.
- R3: At most one read is outstanding. rd_req is a one-cycle pulse raised only while busy, and never in the same cycle as a response or before the previous response has returned.
- R4: Method code 0 (complement polling) deems the write complete on the first response whose bit 7 equals bit 7 of the expected byte.
- R5: Method code 1 (toggle bit) deems the write complete when bit 6 of a response equals bit 6 of the response just before it in the same poll.
- R6: Method codes 2 and 3 (successive reads) deem the write complete when a response equals the response just before it in the same poll.
- R7: If the completing response equals the expected byte, the poll ends with pass=1 and issues no further reads.
- R8: If the completing response differs from the expected byte, exactly two more reads are issued. pass is 1 only if both return the expected byte, and 0 otherwise.
- R9: Once the cycles since start reach the selected limit, no new read is issued before completion. The poll ends with timeout=1 and pass=0. The limit is SECT_LIMIT when long_op=0 and CHIP_LIMIT when long_op=1.
- R10: done is a one-cycle pulse with busy already low. pass and timeout keep their values from that cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a poll (accepted only when idle) |
| method | input | 2 | Completion test: 0 complement, 1 toggle, 2/3 successive |
| long_op | input | 1 | Select the chip-erase time limit |
| target_addr | input | AW | Address to poll |
| expect_data | input | DW | True value of the byte that was written |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | AW | Read address |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | DW | Read response byte |
| busy | output | 1 | Poll in progress |
| done | output | 1 | Poll finished (one-cycle pulse) |
| pass | output | 1 | Write confirmed good |
| timeout | output | 1 | Limit reached before completion |

## Verification
The assertions assume that the device side answers each request with exactly one rd_valid strobe at least one cycle later, and never sends an unrequested response. The one-read-outstanding and no-response-with-request properties depend on this. The bench's responder sees each request and waits a random one to three cycles before it answers once. It then returns a byte from a modelled device: inverted bit 7 and flipping bit 6 while busy, then an optional glitched byte, then the final byte. This keeps every response paired with one request.

// File: rtl/eow_pkg.sv
`timescale 1ns/1ps
package eow_pkg;
  typedef enum logic [1:0] {
    M_CPL  = 2'd0,
    M_TGL  = 2'd1,
    M_SUCC = 2'd2,
    M_SUC3 = 2'd3
  } meth_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2
  } st_e;
endpackage

// File: rtl/eow_timer.sv
`timescale 1ns/1ps
module eow_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] age;

  function automatic logic reached(input logic [CW-1:0] a, input logic [CW-1:0] l);
    return a >= l;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)                      age <= '0;
    else if (clr)                    age <= '0;
    else if (run && !reached(age, limit)) age <= age + 1'b1;
  end

  assign expired = reached(age, limit);
endmodule

// File: rtl/eow_judge.sv
`timescale 1ns/1ps
module eow_judge import eow_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  input  meth_e         meth,
  input  logic [DW-1:0] ref_data,
  output logic          settle_hit,
  output logic          data_ok
);
  localparam int CPL_BIT = DW - 1;
  localparam int TGL_BIT = DW - 2;

  logic [DW-1:0] prev_q;
  logic          have_prev;

  function automatic logic settled(input meth_e m, input logic [DW-1:0] cur,
                                   input logic [DW-1:0] prv, input logic hv,
                                   input logic [DW-1:0] ref_b);
    case (m)
      M_CPL:   return cur[CPL_BIT] == ref_b[CPL_BIT];
      M_TGL:   return hv && (cur[TGL_BIT] == prv[TGL_BIT]);
      default: return hv && (cur == prv);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= '0;
      have_prev <= 1'b0;
    end else if (clr) begin
      have_prev <= 1'b0;
    end else if (rsp_valid) begin
      prev_q    <= rsp_data;
      have_prev <= 1'b1;
    end
  end

  assign settle_hit = rsp_valid && settled(meth, rsp_data, prev_q, have_prev, ref_data);
  assign data_ok    = (rsp_data == ref_data);
endmodule

// File: rtl/eow_poller.sv
`timescale 1ns/1ps
module eow_poller import eow_pkg::*; #(
  parameter int AW            = 19,
  parameter int DW            = 8,
  parameter int SECT_LIMIT    = 1000000,
  parameter int CHIP_LIMIT    = 5000000,
  parameter int CONFIRM_READS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    method,
  input  logic          long_op,
  input  logic [AW-1:0] target_addr,
  input  logic [DW-1:0] expect_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          timeout
);
  localparam int LIM_MAX = (CHIP_LIMIT > SECT_LIMIT) ? CHIP_LIMIT : SECT_LIMIT;
  localparam int CW      = $clog2(LIM_MAX + 1);
  localparam int CFW     = $clog2(CONFIRM_READS + 1);

  st_e           st;
  meth_e         meth_q;
  logic [DW-1:0] exp_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] lim_q;
  logic          confirming;
  logic [CFW-1:0] cf_cnt;
  logic          cf_bad;
  logic          done_q, pass_q, tmo_q;

  logic accept, expired, settle_hit, data_ok, tmo_now, cf_last, rsp_in;

  assign accept  = (st == S_IDLE) && start;
  assign busy    = (st != S_IDLE);
  assign tmo_now = !confirming && expired;
  assign cf_last = (cf_cnt == CFW'(CONFIRM_READS - 1));
  assign rsp_in  = rd_valid && (st == S_WAIT);

  eow_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(accept), .run(busy),
    .limit(lim_q), .expired(expired)
  );

  eow_judge #(.DW(DW)) u_judge (
    .clk(clk), .rst_n(rst_n), .clr(accept), .rsp_valid(rsp_in),
    .rsp_data(rd_data), .meth(meth_q), .ref_data(exp_q),
    .settle_hit(settle_hit), .data_ok(data_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; meth_q <= M_CPL; exp_q <= '0; addr_q <= '0; lim_q <= '0;
      confirming <= 1'b0; cf_cnt <= '0; cf_bad <= 1'b0;
      done_q <= 1'b0; pass_q <= 1'b0; tmo_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          meth_q     <= meth_e'(method);
          exp_q      <= expect_data;
          addr_q     <= target_addr;
          lim_q      <= long_op ? CW'(CHIP_LIMIT) : CW'(SECT_LIMIT);
          confirming <= 1'b0;
          cf_cnt     <= '0;
          cf_bad     <= 1'b0;
          pass_q     <= 1'b0;
          tmo_q      <= 1'b0;
          st         <= S_ISSUE;
        end
        S_ISSUE: begin
          if (tmo_now) begin
            st <= S_IDLE; done_q <= 1'b1; tmo_q <= 1'b1; pass_q <= 1'b0;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WAIT: if (rd_valid) begin
          if (confirming) begin
            if (cf_last) begin
              st <= S_IDLE; done_q <= 1'b1; pass_q <= !cf_bad && data_ok;
            end else begin
              cf_cnt <= cf_cnt + 1'b1;
              cf_bad <= cf_bad | !data_ok;
              st     <= S_ISSUE;
            end
          end else if (settle_hit) begin
            if (data_ok) begin
              st <= S_IDLE; done_q <= 1'b1; pass_q <= 1'b1;
            end else begin
              confirming <= 1'b1;
              st         <= S_ISSUE;
            end
          end else begin
            st <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_req  = (st == S_ISSUE) && !tmo_now;
  assign rd_addr = addr_q;
  assign done    = done_q;
  assign pass    = pass_q;
  assign timeout = tmo_q;
endmodule

// File: rtl/eow_poller_chk.sv
`timescale 1ns/1ps
module eow_poller_chk #(
  parameter int AW         = 19,
  parameter int SECT_LIMIT = 1000000,
  parameter int CHIP_LIMIT = 5000000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          long_op,
  input logic          busy,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          done,
  input logic          pass,
  input logic          timeout,
  input logic          expired
);
  logic        pend, armed;
  logic [31:0] age_c, lim_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; armed <= 1'b0; age_c <= '0; lim_c <= '0;
    end else begin
      armed <= 1'b1;
      if (rd_req) pend <= 1'b1;
      else if (rd_valid) pend <= 1'b0;
      if (start && !busy) begin
        age_c <= '0;
        lim_c <= long_op ? 32'(CHIP_LIMIT) : 32'(SECT_LIMIT);
      end else if (age_c != 32'hFFFF_FFFF) begin
        age_c <= age_c + 1;
      end
    end
  end

  AST_ONE_READ:    assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> !pend);       // R3
  AST_NO_REQ_RSP:  assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> !rd_req);   // R3
  AST_REQ_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> busy);        // R3
  AST_ADDR_HELD:   assert property (@(posedge clk) disable iff (!rst_n)
                     (armed && busy && $past(busy)) |-> $stable(rd_addr));                        // R2
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);         // R10
  AST_DONE_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);         // R10
  AST_TMO_NOPASS:  assert property (@(posedge clk) disable iff (!rst_n) (done && timeout) |-> !pass); // R9
  AST_TMO_LATE:    assert property (@(posedge clk) disable iff (!rst_n)
                     (done && timeout) |-> (age_c >= lim_c));                                     // R9
  AST_TMO_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
                     (armed && done && timeout) |-> $past(expired));                              // R9
  AST_END_ON_RSP:  assert property (@(posedge clk) disable iff (!rst_n)
                     (armed && done && !timeout) |-> $past(rd_valid));                            // R7
endmodule

bind eow_poller eow_poller_chk #(
  .AW(AW), .SECT_LIMIT(SECT_LIMIT), .CHIP_LIMIT(CHIP_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .long_op(long_op), .busy(busy),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .done(done),
  .pass(pass), .timeout(timeout), .expired(expired)
);

// File: tb/eow_poller_tb.sv
`timescale 1ns/1ps
module eow_poller_tb;
  localparam int AW = 19, DW = 8, SECT = 200, CHIP = 500;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, long_op = 1'b0;
  logic [1:0] method = '0;
  logic [AW-1:0] target_addr = '0;
  logic [DW-1:0] expect_data = '0, rd_data = '0;
  logic rd_valid = 1'b0;
  logic rd_req, busy, done, pass, timeout;
  logic [AW-1:0] rd_addr;

  int checks = 0, fails = 0;
  int nreads, bad_addr, overlap;
  bit sc_forever, sc_glitch, sc_t0;
  int sc_n, sc_lat;
  logic [7:0] sc_exp, sc_final;
  logic [5:0] sc_junk;
  logic [AW-1:0] sc_addr;

  always #2 clk = ~clk;

  eow_poller #(.AW(AW), .DW(DW), .SECT_LIMIT(SECT), .CHIP_LIMIT(CHIP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .method(method), .long_op(long_op),
    .target_addr(target_addr), .expect_data(expect_data), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .done(done), .pass(pass), .timeout(timeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Modelled device byte for the i-th read (1-based) of the current poll
  function automatic logic [7:0] dev_byte(input int i);
    if (sc_forever || i <= sc_n) return {~sc_exp[7], sc_t0 ^ i[0], sc_junk};
    if (i == sc_n + 1 && sc_glitch) return sc_final ^ 8'h03;
    return sc_final;
  endfunction

  // Outcome predicted from the requirements
  task automatic predict(input int m, output bit p, output bit t, output int nr);
    logic [7:0] d, prv;
    bit hv, det;
    p = 0; t = 1; nr = -1; hv = 0; prv = '0;
    if (sc_forever) return;
    for (int i = 1; i <= sc_n + 4; i++) begin
      d = dev_byte(i);
      if (m == 0)      det = (d[7] == sc_exp[7]);
      else if (m == 1) det = hv && (d[6] == prv[6]);
      else             det = hv && (d == prv);
      if (det) begin
        t = 0;
        if (d == sc_exp) begin p = 1; nr = i; end
        else begin p = (dev_byte(i + 1) == sc_exp) && (dev_byte(i + 2) == sc_exp); nr = i + 2; end
        return;
      end
      prv = d; hv = 1;
    end
  endtask

  // Responder: one answer per request after sc_lat cycles
  initial begin
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (rd_req) begin
        nreads++;
        if (rd_addr !== sc_addr) bad_addr++;
        for (int k = 0; k < sc_lat; k++) begin
          @(negedge clk);
          if (rd_req) overlap++;
        end
        rd_valid = 1'b1;
        rd_data  = dev_byte(nreads);
      end
    end
  end

  initial begin
    #(150000 * 4);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic run_case(input int m, input int n, input bit fv, input bit gl,
                          input logic [7:0] fin, input logic [7:0] ex, input bit lop,
                          input bit restart, input string tag);
    bit ep, et; int er, cyc;
    sc_n = n; sc_forever = fv; sc_glitch = gl; sc_final = fin; sc_exp = ex;
    sc_t0 = $urandom_range(0, 1); sc_junk = 6'($urandom); sc_lat = $urandom_range(1, 3);
    sc_addr = AW'($urandom);
    predict(m, ep, et, er);
    nreads = 0; bad_addr = 0; overlap = 0;
    @(negedge clk);
    start = 1; method = 2'(m); long_op = lop; target_addr = sc_addr; expect_data = ex;
    @(negedge clk);
    start = 0; method = 2'(m + 1); long_op = ~lop; target_addr = ~sc_addr; expect_data = ~ex;
    check(busy === 1'b1, {"R10 busy ", tag}, busy, 1);
    cyc = 1;
    while (done !== 1'b1 && cyc < 4000) begin
      if (restart && cyc == 3) start = 1; else start = 0;
      @(negedge clk); cyc++;
    end
    start = 0;
    check(done === 1'b1, {"R10 done ", tag}, done, 1);
    check(busy === 1'b0, {"R10 idle at done ", tag}, busy, 0);
    check(timeout === et, {"R9 timeout ", tag}, timeout, et);
    check(pass === ep, {"R7 R8 pass ", tag}, pass, ep);
    if (!et) check(nreads == er, {"R4 R5 R6 R8 reads ", tag}, nreads, er);
    else begin
      int lim = lop ? CHIP : SECT;
      check(cyc >= lim && cyc <= lim + 8, {"R9 limit ", tag}, cyc, lim);
    end
    check(bad_addr == 0 && overlap == 0, {"R2 R3 addr/overlap ", tag}, bad_addr + overlap, 0);
    @(negedge clk);
    check(done === 1'b0 && pass === ep && timeout === et, {"R10 hold ", tag}, {done, pass, timeout}, {1'b0, ep, et});
    repeat (4) @(negedge clk);
    check(nreads == (et ? nreads : er), {"R7 no reads after done ", tag}, nreads, er);
  endtask

  initial begin
    sc_lat = 1; sc_addr = '0; sc_exp = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && pass === 0 && timeout === 0 && rd_req === 0,
          "R1 reset state", {busy, done, pass, timeout, rd_req}, 0);
    rst_n = 1;
    @(negedge clk);
    check(busy === 0 && rd_req === 0, "R1 idle after reset", {busy, rd_req}, 0);

    run_case(0, 3, 0, 0, 8'hA5, 8'hA5, 0, 0, "R4 complement");
    run_case(1, 4, 0, 0, 8'h3C, 8'h3C, 0, 0, "R5 toggle");
    run_case(2, 2, 0, 0, 8'h5A, 8'h5A, 0, 0, "R6 successive");
    run_case(3, 0, 0, 0, 8'h81, 8'h81, 0, 0, "R6 code3");
    run_case(0, 2, 0, 1, 8'hC7, 8'hC7, 0, 0, "R8 glitch pass");
    run_case(0, 1, 0, 0, 8'hC4, 8'hC7, 0, 0, "R8 bad data fail");
    run_case(2, 3, 0, 1, 8'h12, 8'h12, 0, 1, "R2 restart ignored");
    run_case(0, 0, 1, 0, 8'h00, 8'h80, 0, 0, "R9 sector timeout");
    run_case(1, 0, 1, 0, 8'h00, 8'h40, 1, 0, "R9 chip timeout");

    for (int r = 0; r < 30; r++) begin
      logic [7:0] ex, fin;
      ex  = 8'($urandom);
      fin = ($urandom_range(0, 3) == 0) ? (ex ^ 8'($urandom_range(1, 255))) : ex;
      run_case($urandom_range(0, 3), $urandom_range(0, 5), 0, $urandom_range(0, 1),
               fin, ex, $urandom_range(0, 1), $urandom_range(0, 1), "random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule